// File: doc/BRIEF.md
# Constant-Driven Shader Flow Sequencer

This block is the flow-control front end of a small programmable vertex engine. The host fills a 256-slot instruction store and drives a vector of boolean condition constants and a bank of 8-bit iteration counts. A start pulse snapshots those constants, and the block walks the program from slot 0. It puts one instruction index per cycle on its issue port for a downstream datapath, which is outside this block.

The program can steer execution with jumps, conditional subroutine calls with returns, and single-level counted loops. Every decision is taken from the snapshot, never from computed results. The path through the program is therefore fixed for a whole primitive. The host may set new constants before the next start, so successive primitives can follow different paths through the same code. The block checks load-time and run-time misuse and bounds the number of instructions one primitive may execute.

Top module: `shader_seq_top`

## Requirements
- R1: The store holds 256 slots of 16 bits, written through `wrEn`/`wrAddr`/`wrData`. An instruction word is: opcode in bits [15:12], selector in bits [11:8], target slot in bits [7:0]. Opcodes: 0 plain, 1 jump, 2 jump-if-flag, 3 call-if-flag, 4 return, 5 loop-begin, 6 loop-close, 7 end. Any other opcode executes as plain.
- R2: A `start` accepted while idle makes the block busy. Starting in the next cycle, it issues one index per cycle on `issueIdx` with `issueValid` high, beginning at slot 0. A plain instruction at slot p is followed by slot p+1.
- R3: Writing a loop-begin opcode into slot 255 sets `loadErr`. Writing any other opcode there clears it. While `loadErr` is high, `start` is ignored and `busy` stays low.
- R4: Jump always continues at the target. Jump-if-flag continues at the target when the selected condition bit is 1, and at p+1 otherwise. Call-if-flag with a 1 bit pushes p+1 and continues at the target; with a 0 bit it continues at p+1. Return continues at the most recently pushed slot. The selector's low bits index the condition vector.
- R5: Condition bits and counts are captured when `start` is accepted. Host changes made while busy do not affect the running primitive, but they do apply to the next one.
- R6: Loop-begin reads count n from the bank entry picked by the selector, and its target names the matching loop-close. For n ≥ 1 the slots between them execute n times before the slot after loop-close. For n = 0 execution jumps straight to target+1.
- R7: With MAX_INSTR = L, a primitive issues at most L instructions. When an (L+1)-th would be issued, nothing is issued, `overrun` is set and the primitive ends.
- R8: The return stack holds STACK_D entries. A taken call when full, or a return when empty, is issued, sets `runErr` and ends the primitive.
- R9: Loop-begin while a loop is active, or loop-close while none is, is issued, sets `runErr` and ends the primitive.
- R10: A primitive ends after an end opcode or after slot 255 is issued, whatever the opcode there. `done` is high for exactly the one cycle after the last issue, and the block is then idle.
- R11: `runErr` and `overrun` hold until the next accepted `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Instruction store write strobe |
| wrAddr | input | 8 | Slot being written |
| wrData | input | 16 | Instruction word |
| hostFlags | input | FLAG_N | Condition constants |
| hostCounts | input | CNT_N*CNT_W | Iteration count bank, entry k at bits [k*CNT_W +: CNT_W] |
| start | input | 1 | Begin a primitive |
| issueValid | output | 1 | An index is being issued this cycle |
| issueIdx | output | 8 | Slot index being issued |
| busy | output | 1 | A primitive is executing |
| done | output | 1 | One-cycle end-of-primitive pulse |
| runErr | output | 1 | Stack or loop misuse seen |
| overrun | output | 1 | Instruction budget exceeded |
| loadErr | output | 1 | Illegal loop-begin in the last slot |

## Verification
The bench builds the block with eight condition bits, four counts, a two-entry return stack and an instruction budget of 100. The small stack lets a self-calling routine overflow after three issues. The small budget means a 255-iteration loop crosses the limit in about a hundred cycles instead of tens of thousands. One fixed program is run under five constant sets, and each produces a distinct path whose issue count and index sum are known in advance. Separate short programs then provoke each error and the slot-255 ending.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int INSTR_W = 16;
  localparam int SEL_W   = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_JMP  = 4'd1,
    OP_JIF  = 4'd2,
    OP_CALL = 4'd3,
    OP_RET  = 4'd4,
    OP_LOOP = 4'd5,
    OP_LEND = 4'd6,
    OP_END  = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    PC_SEQ  = 3'd0,
    PC_TGT  = 3'd1,
    PC_POP  = 3'd2,
    PC_REP  = 3'd3,
    PC_SKIP = 3'd4,
    PC_ZERO = 3'd5
  } pcsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   latchConst;
    logic   pcWe;
    pcsel_e pcSel;
    logic   push;
    logic   pop;
    logic   loopArm;
    logic   loopDec;
    logic   loopEnd;
    logic   cntInc;
  } ctl_t;

  // decoded state from datapath to control
  typedef struct packed {
    op_e  op;
    logic flagBit;
    logic cntZero;
    logic loopActive;
    logic remMore;
    logic stFull;
    logic stEmpty;
    logic isLast;
    logic atLimit;
    logic loadErr;
  } stat_t;
endpackage

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter int FLAG_N    = 16,
  parameter int CNT_N     = 4,
  parameter int CNT_W     = 8,
  parameter int STACK_D   = 4,
  parameter int MAX_INSTR = 65026
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [INSTR_W-1:0]      wrData,
  input  logic [FLAG_N-1:0]       hostFlags,
  input  logic [CNT_N*CNT_W-1:0]  hostCounts,
  input  ctl_t                    ctl,
  output stat_t                   st,
  output logic [ADDR_W-1:0]       pc
);
  localparam int FI_W  = $clog2(FLAG_N);
  localparam int CI_W  = $clog2(CNT_N);
  localparam int SP_W  = $clog2(STACK_D + 1);
  localparam int CW    = $clog2(MAX_INSTR + 1);
  localparam logic [CW-1:0]     LIMIT = CW'(MAX_INSTR);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);

  logic [INSTR_W-1:0] mem [DEPTH];
  logic [INSTR_W-1:0] instr;
  logic [SEL_W-1:0]   sel;
  logic [ADDR_W-1:0]  tgt;
  logic [FLAG_N-1:0]  shFlags;
  logic [CNT_W-1:0]   shCounts [CNT_N];
  logic [CNT_W-1:0]   cntSel;
  logic [SP_W-1:0]    sp;
  logic [ADDR_W-1:0]  stk [STACK_D];
  logic [ADDR_W-1:0]  topEntry;
  logic [ADDR_W-1:0]  pcNext;
  logic               loopActive;
  logic [ADDR_W-1:0]  loopHead;
  logic [CNT_W-1:0]   rem;
  logic [CW-1:0]      instrCnt;
  logic               loadErrQ;

  // instruction store
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadErrQ <= 1'b0;
    else if (wrEn && wrAddr == LAST) loadErrQ <= (wrData[15:12] == OP_LOOP);
  end

  always_comb begin
    instr = mem[pc];
    sel   = instr[11:8];
    tgt   = instr[7:0];
  end

  // constant snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shFlags <= '0;
    else if (ctl.latchConst) shFlags <= hostFlags;
  end

  for (genvar k = 0; k < CNT_N; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shCounts[k] <= '0;
      else if (ctl.latchConst) shCounts[k] <= hostCounts[k*CNT_W +: CNT_W];
    end
  end

  assign cntSel = shCounts[sel[CI_W-1:0]];

  // return stack
  for (genvar i = 0; i < STACK_D; i++) begin : g_stk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stk[i] <= '0;
      else if (ctl.push && sp == SP_W'(i)) stk[i] <= pc + ADDR_W'(1);
    end
  end

  always_comb begin
    topEntry = '0;
    for (int i = 0; i < STACK_D; i++) begin
      if (sp == SP_W'(i + 1)) topEntry = stk[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sp <= '0;
    else if (ctl.latchConst) sp <= '0;
    else if (ctl.push) sp <= sp + SP_W'(1);
    else if (ctl.pop) sp <= sp - SP_W'(1);
  end

  // loop state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopActive <= 1'b0;
      loopHead   <= '0;
      rem        <= '0;
    end else if (ctl.latchConst || ctl.loopEnd) begin
      loopActive <= 1'b0;
    end else if (ctl.loopArm) begin
      loopActive <= 1'b1;
      loopHead   <= pc + ADDR_W'(1);
      rem        <= cntSel;
    end else if (ctl.loopDec) begin
      rem <= rem - CNT_W'(1);
    end
  end

  // issued-instruction budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) instrCnt <= '0;
    else if (ctl.latchConst) instrCnt <= '0;
    else if (ctl.cntInc) instrCnt <= instrCnt + CW'(1);
  end

  // program counter
  always_comb begin
    case (ctl.pcSel)
      PC_TGT:  pcNext = tgt;
      PC_POP:  pcNext = topEntry;
      PC_REP:  pcNext = loopHead;
      PC_SKIP: pcNext = tgt + ADDR_W'(1);
      PC_ZERO: pcNext = '0;
      default: pcNext = pc + ADDR_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else if (ctl.pcWe) pc <= pcNext;
  end

  always_comb begin
    st.op         = op_e'(instr[15:12]);
    st.flagBit    = shFlags[sel[FI_W-1:0]];
    st.cntZero    = (cntSel == '0);
    st.loopActive = loopActive;
    st.remMore    = (rem > CNT_W'(1));
    st.stFull     = (sp == SP_W'(STACK_D));
    st.stEmpty    = (sp == '0);
    st.isLast     = (pc == LAST);
    st.atLimit    = (instrCnt == LIMIT);
    st.loadErr    = loadErrQ;
  end

  // control never pushes onto a full stack or pops an empty one
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (sp != SP_W'(STACK_D)));
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> (sp != '0));
  // a loop repeat only happens inside an armed loop with passes left
  a_r6_dec_in_loop: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loopDec |-> (loopActive && rem > CNT_W'(1)));
  // the budget counter never passes its limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    instrCnt <= LIMIT);
  // snapshot only moves on an accepted start
  a_r5_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchConst |=> $stable(shFlags));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  stat_t st,
  output ctl_t  ctl,
  output logic  issueValid,
  output logic  busy,
  output logic  done,
  output logic  runErr,
  output logic  overrun
);
  typedef enum logic {S_IDLE, S_RUN} state_e;
  state_e state;
  logic finish, fault, over;

  always_comb begin
    ctl    = '0;
    finish = 1'b0;
    fault  = 1'b0;
    over   = 1'b0;
    if (state == S_IDLE) begin
      if (start && !st.loadErr) begin
        ctl.latchConst = 1'b1;
        ctl.pcWe       = 1'b1;
        ctl.pcSel      = PC_ZERO;
      end
    end else if (st.atLimit) begin
      over = 1'b1;
    end else begin
      ctl.cntInc = 1'b1;
      ctl.pcWe   = 1'b1;
      ctl.pcSel  = PC_SEQ;
      case (st.op)
        OP_JMP: ctl.pcSel = PC_TGT;
        OP_JIF: if (st.flagBit) ctl.pcSel = PC_TGT;
        OP_CALL: begin
          if (st.flagBit) begin
            if (st.stFull) fault = 1'b1;
            else begin
              ctl.push  = 1'b1;
              ctl.pcSel = PC_TGT;
            end
          end
        end
        OP_RET: begin
          if (st.stEmpty) fault = 1'b1;
          else begin
            ctl.pop   = 1'b1;
            ctl.pcSel = PC_POP;
          end
        end
        OP_LOOP: begin
          if (st.loopActive) fault = 1'b1;
          else if (st.cntZero) ctl.pcSel = PC_SKIP;
          else ctl.loopArm = 1'b1;
        end
        OP_LEND: begin
          if (!st.loopActive) fault = 1'b1;
          else if (st.remMore) begin
            ctl.loopDec = 1'b1;
            ctl.pcSel   = PC_REP;
          end else begin
            ctl.loopEnd = 1'b1;
          end
        end
        OP_END:  finish = 1'b1;
        default: ;
      endcase
      if (st.isLast && !fault) finish = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      runErr  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= finish | fault | over;
      if (ctl.latchConst) begin
        state   <= S_RUN;
        runErr  <= 1'b0;
        overrun <= 1'b0;
      end else if (finish | fault | over) begin
        state <= S_IDLE;
      end
      if (fault) runErr <= 1'b1;
      if (over) overrun <= 1'b1;
    end
  end

  assign busy       = (state == S_RUN);
  assign issueValid = (state == S_RUN) && !st.atLimit;

  // end-of-primitive strobe never lasts two cycles
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // an illegal program keeps the block idle
  a_r3_start_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && st.loadErr) |=> !busy);
  // a budget stop ends the primitive
  a_r7_over_stops: assert property (@(posedge clk) disable iff (!rstN)
    (busy && st.atLimit) |=> (!busy && overrun));
endmodule

// File: rtl/shader_seq_top.sv
module shader_seq_top
  import seq_pkg::*;
#(
  parameter int FLAG_N    = 16,
  parameter int CNT_N     = 4,
  parameter int CNT_W     = 8,
  parameter int STACK_D   = 4,
  parameter int MAX_INSTR = 65026
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [7:0]             wrAddr,
  input  logic [15:0]            wrData,
  input  logic [FLAG_N-1:0]      hostFlags,
  input  logic [CNT_N*CNT_W-1:0] hostCounts,
  input  logic                   start,
  output logic                   issueValid,
  output logic [7:0]             issueIdx,
  output logic                   busy,
  output logic                   done,
  output logic                   runErr,
  output logic                   overrun,
  output logic                   loadErr
);
  ctl_t  ctl;
  stat_t st;

  seq_dp #(
    .FLAG_N(FLAG_N), .CNT_N(CNT_N), .CNT_W(CNT_W),
    .STACK_D(STACK_D), .MAX_INSTR(MAX_INSTR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hostFlags(hostFlags), .hostCounts(hostCounts),
    .ctl(ctl), .st(st), .pc(issueIdx)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .st(st), .ctl(ctl),
    .issueValid(issueValid), .busy(busy), .done(done),
    .runErr(runErr), .overrun(overrun)
  );

  assign loadErr = st.loadErr;
endmodule

// File: tb/tb_shader_seq_top.sv
module tb_shader_seq_top;
  localparam int FLAG_N = 8;
  localparam int CNT_N  = 4;
  localparam int CNT_W  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [FLAG_N-1:0] hostFlags = '0;
  logic [CNT_N*CNT_W-1:0] hostCounts = '0;
  logic        start = 1'b0;
  logic        issueValid, busy, done, runErr, overrun, loadErr;
  logic [7:0]  issueIdx;

  int checks = 0;
  int fails  = 0;
  int rCnt, rSum;
  logic rDoneAfter;

  always #10 clk = ~clk;

  shader_seq_top #(
    .FLAG_N(FLAG_N), .CNT_N(CNT_N), .CNT_W(CNT_W),
    .STACK_D(2), .MAX_INSTR(100)
  ) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hostFlags(hostFlags), .hostCounts(hostCounts), .start(start),
    .issueValid(issueValid), .issueIdx(issueIdx), .busy(busy), .done(done),
    .runErr(runErr), .overrun(overrun), .loadErr(loadErr)
  );

  typedef struct packed {
    logic [7:0]  flg;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic [15:0] sum;
    logic        ovr;
  } vec_t;

  // constant sets for the shared program: flags, loop count, issues, index sum, overrun
  localparam vec_t VEC [5] = '{
    '{8'h01, 8'd1,   16'd9,   16'd48,  1'b0},
    '{8'h02, 8'd2,   16'd13,  16'd84,  1'b0},
    '{8'h03, 8'd3,   16'd17,  16'd119, 1'b0},
    '{8'h00, 8'd255, 16'd100, 16'd486, 1'b1},
    '{8'h00, 8'd0,   16'd5,   16'd13,  1'b0}
  };

  function automatic logic [15:0] mk(input int op, input int sel, input int tgt);
    return {4'(op), 4'(sel), 8'(tgt)};
  endfunction

  function automatic logic [31:0] cnts(input logic [7:0] n);
    return {8'd0, 8'd0, n, 8'd9};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fillPlain();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 8'(a); wrData = mk(0, 0, 0);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runPrim(input logic swap, input logic [7:0] swFlg, input logic [31:0] swCnt);
    int guard;
    rCnt = 0; rSum = 0; guard = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (swap) begin
      hostFlags = swFlg;
      hostCounts = swCnt;
    end
    while (!done && guard < 5000) begin
      if (issueValid) begin
        rCnt++;
        rSum += int'(issueIdx);
      end
      guard++;
      @(negedge clk);
    end
    if (guard >= 5000) chk("R10 done never seen", 0, 1);
    @(negedge clk);
    rDoneAfter = done;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 R10 R11 reset state
    chk("R2 busy after reset", busy, 0);
    chk("R2 issueValid after reset", issueValid, 0);
    chk("R10 done after reset", done, 0);
    chk("R11 runErr after reset", runErr, 0);
    chk("R11 overrun after reset", overrun, 0);
    chk("R3 loadErr after reset", loadErr, 0);

    // R1 shared program
    fillPlain();
    wr(0,  mk(2, 0, 10));  // jump-if flag0 -> 10
    wr(2,  mk(3, 1, 20));  // call-if flag1 -> 20
    wr(3,  mk(5, 1, 6));   // loop count[1], close at 6
    wr(6,  mk(6, 0, 0));
    wr(7,  mk(7, 0, 0));
    wr(11, mk(1, 0, 2));
    wr(21, mk(4, 0, 0));

    // R4 R6 R7 R11 table walk
    for (int v = 0; v < 5; v++) begin
      hostFlags = VEC[v].flg;
      hostCounts = cnts(VEC[v].n);
      runPrim(1'b0, '0, '0);
      chk($sformatf("R4 R6 issue count vec%0d", v), rCnt, int'(VEC[v].cnt));
      chk($sformatf("R4 R6 index sum vec%0d", v), rSum, int'(VEC[v].sum));
      chk($sformatf("R7 R11 overrun vec%0d", v), overrun, int'(VEC[v].ovr));
      chk($sformatf("R8 runErr vec%0d", v), runErr, 0);
    end
    chk("R10 done one cycle", rDoneAfter, 0);
    chk("R10 idle after end", busy, 0);

    // R5 snapshot: host changes mid-run apply to next primitive only
    hostFlags = 8'h00; hostCounts = cnts(8'd0);
    runPrim(1'b1, 8'h03, cnts(8'd3));
    chk("R5 running primitive keeps old constants cnt", rCnt, 5);
    chk("R5 running primitive keeps old constants sum", rSum, 13);
    runPrim(1'b0, '0, '0);
    chk("R5 next primitive uses new constants cnt", rCnt, 17);
    chk("R5 next primitive uses new constants sum", rSum, 119);

    // R3 loop-begin in the last slot
    wr(255, mk(5, 0, 0));
    chk("R3 loadErr set", loadErr, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 start ignored busy", busy, 0);
    chk("R3 start ignored issue", issueValid, 0);
    @(negedge clk);
    chk("R3 start ignored done", done, 0);
    wr(255, mk(0, 0, 0));
    chk("R3 loadErr cleared", loadErr, 0);

    // R8 return with empty stack
    fillPlain();
    wr(0, mk(4, 0, 0));
    runPrim(1'b0, '0, '0);
    chk("R8 empty return issues", rCnt, 1);
    chk("R8 empty return runErr", runErr, 1);

    // R8 call overflow, two-deep stack
    wr(0, mk(3, 0, 0));
    hostFlags = 8'h01;
    runPrim(1'b0, '0, '0);
    chk("R8 call overflow issues", rCnt, 3);
    chk("R8 call overflow runErr", runErr, 1);
    chk("R11 runErr holds after end", runErr, 1);

    // R9 nested loop-begin
    wr(0, mk(5, 1, 5));
    wr(1, mk(5, 1, 4));
    hostCounts = cnts(8'd2);
    runPrim(1'b0, '0, '0);
    chk("R9 nested loop issues", rCnt, 2);
    chk("R9 nested loop runErr", runErr, 1);

    // R9 loop-close with no loop
    wr(0, mk(6, 0, 0));
    runPrim(1'b0, '0, '0);
    chk("R9 stray close issues", rCnt, 1);
    chk("R9 stray close runErr", runErr, 1);

    // R10 ending by reaching slot 255; R11 clears the error
    wr(0, mk(1, 0, 254));
    runPrim(1'b0, '0, '0);
    chk("R10 last slot issues", rCnt, 3);
    chk("R10 last slot sum", rSum, 509);
    chk("R11 runErr cleared by start", runErr, 0);
    chk("R10 done one cycle at last slot", rDoneAfter, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule